// File: doc/BRIEF.md
# Device-to-Memory Byte Transfer Engine

This block copies a run of bytes from one peripheral data port into memory with no processor help once a job is launched. Software presents a first memory address and a byte total on the control inputs and pulses `start`. The engine then spends a fixed preparation period before it touches either port. After that it repeats a two-clock step for each byte. In the first clock it takes a byte from the device, and only when the device reports ready. In the second clock it writes that byte to memory at the current address. After each write the address goes up by one and the remaining total goes down by one.

When the remaining total reaches zero, the engine raises a single-cycle completion pulse and returns to idle. Data only ever moves from the device toward memory. With the default parameters and a device that is always ready, a 500-byte job takes 20 + 2·500 = 1020 cycles from the start edge to the completion cycle.

Top module: `dma_byte_mover`

## Requirements
- R1: After reset, `busy`, `done`, `devRead` and `memWe` are all 0.
- R2: A `start` pulse sampled while idle latches `startAddr` and `byteCount`, and `busy` is 1 in the cycle that follows that edge (cycle 0 of the job).
- R3: Counting cycles from the start edge as cycle 0, no device read happens before cycle SETUP_CYCLES (20 by default). With the device ready, the first `devRead` occurs in exactly that cycle.
- R4: Each byte takes exactly two clocks. `devRead` is 1 in one cycle, and `memWe` is 1 in the next cycle with `memData` equal to the byte that was on `devData` in the read cycle.
- R5: The k-th write (k from 0) goes to address `startAddr + k`, modulo 2^ADDR_W, so a job may wrap from all-ones to zero.
- R6: In a cycle where the engine wants a byte and `devReady` is 0, there is no read and no write, and neither the address nor the remaining total changes. The byte step resumes in the first cycle `devReady` is 1.
- R7: `done` is 1 for exactly one cycle: cycle SETUP_CYCLES + 2·N + S, where N is the byte total and S is the number of stalled cycles. In the next cycle both `done` and `busy` are 0.
- R8: A `start` seen while `busy` is 1 is ignored. The running job keeps its address, total and timing.
- R9: A byte total of 0 performs no read and no write, and `done` pulses in cycle SETUP_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, honoured only while idle |
| startAddr | input | ADDR_W | First memory address of the job |
| byteCount | input | CNT_W | Number of bytes to move |
| devData | input | DATA_W | Byte offered by the device |
| devReady | input | 1 | Device has a byte available |
| devRead | output | 1 | Byte taken from the device this cycle |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | DATA_W | Memory write data |
| busy | output | 1 | Job in progress (from the start edge through the done cycle) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps the default parameters: 16-bit addresses, a 10-bit byte total, 8-bit data and a 20-cycle preparation period. With these values a full 500-byte job fits in about a thousand cycles, so the bench can run it. The 16-bit address also lets a short job starting at 0xFFFE wrap through zero. The 10-bit total reaches the full job length, and small totals of 0 and 1 test the loop's entry and exit edges. Stalled-ready jobs and a start pulse in the middle of a job show that the setup counter and the two-cycle step stay locked to the first start.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WRITE,
    ST_FINISH
  } dmaState_e;

  typedef struct packed {
    logic load;     // latch address and total
    logic capture;  // take device byte
    logic advance;  // bump address, drop total
  } dmaStrobe_t;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [DATA_W-1:0] devData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              cntZero,
  output logic              cntLast
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '0;
    end else if (stb.load) begin
      addrQ <= startAddr;
      cntQ  <= byteCount;
    end else if (stb.advance) begin
      addrQ <= addrQ + 1'b1;
      cntQ  <= cntQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataQ <= '0;
    else if (stb.capture) dataQ <= devData;
  end

  assign memAddr = addrQ;
  assign memData = dataQ;
  assign cntZero = (cntQ == '0);
  assign cntLast = (cntQ == ONE);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.load) |=> (addrQ == $past(addrQ) + 1'b1));

  // R6
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.advance) |=> ($stable(addrQ) && $stable(cntQ)));

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int SETUP_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       devReady,
  input  logic       cntZero,
  input  logic       cntLast,
  output dmaStrobe_t stb,
  output logic       devRead,
  output logic       memWe,
  output logic       busy,
  output logic       done
);

  localparam int SW = (SETUP_CYCLES > 1) ? $clog2(SETUP_CYCLES) : 1;
  localparam logic [SW-1:0] SLAST = SW'(SETUP_CYCLES - 1);

  dmaState_e     state, stateNext;
  logic [SW-1:0] setupCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_SETUP;
      ST_SETUP:  if (setupCnt == SLAST) stateNext = cntZero ? ST_FINISH : ST_READ;
      ST_READ:   if (devReady) stateNext = ST_WRITE;
      ST_WRITE:  stateNext = cntLast ? ST_FINISH : ST_READ;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  setupCnt <= '0;
    else if (state != ST_SETUP) setupCnt <= '0;
    else                        setupCnt <= setupCnt + 1'b1;
  end

  assign devRead     = (state == ST_READ) && devReady;
  assign memWe       = (state == ST_WRITE);
  assign done        = (state == ST_FINISH);
  assign busy        = (state != ST_IDLE);
  assign stb.load    = (state == ST_IDLE) && start;
  assign stb.capture = devRead;
  assign stb.advance = memWe;

  // R3
  setup_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP && setupCnt != SLAST) |=> (state == ST_SETUP));

  // R4
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    devRead |=> (memWe && !devRead));

  // R6
  stall_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && !devReady) |=> (state == ST_READ));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/dma_byte_mover.sv
module dma_byte_mover
  import dma_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CNT_W        = 10,
  parameter int DATA_W       = 8,
  parameter int SETUP_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [DATA_W-1:0] devData,
  input  logic              devReady,
  output logic              devRead,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              busy,
  output logic              done
);

  dmaStrobe_t stb;
  logic       cntZero, cntLast;

  dma_ctrl #(.SETUP_CYCLES(SETUP_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .devReady(devReady),
    .cntZero(cntZero), .cntLast(cntLast), .stb(stb),
    .devRead(devRead), .memWe(memWe), .busy(busy), .done(done)
  );

  dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .startAddr(startAddr),
    .byteCount(byteCount), .devData(devData), .memAddr(memAddr),
    .memData(memData), .cntZero(cntZero), .cntLast(cntLast)
  );

  // R4
  no_idle_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

endmodule

// File: tb/tb_dma_byte_mover.sv
module tb_dma_byte_mover;

  localparam int SETUP = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] startAddr = '0;
  logic [9:0]  byteCount = '0;
  logic [7:0]  devData = '0;
  logic        devReady = 1'b0;
  logic        devRead, memWe, busy, done;
  logic [15:0] memAddr;
  logic [7:0]  memData;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_byte_mover dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .byteCount(byteCount), .devData(devData), .devReady(devReady),
    .devRead(devRead), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .busy(busy), .done(done)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [9:0]  cnt;
    logic [7:0]  stall;
    logic        midStart;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{addr: 16'h1000, cnt: 10'd1,   stall: 8'd0, midStart: 1'b0},
    '{addr: 16'h0200, cnt: 10'd5,   stall: 8'd0, midStart: 1'b0},
    '{addr: 16'hFFFE, cnt: 10'd4,   stall: 8'd0, midStart: 1'b0},
    '{addr: 16'h0040, cnt: 10'd3,   stall: 8'd4, midStart: 1'b0},
    '{addr: 16'h0800, cnt: 10'd6,   stall: 8'd0, midStart: 1'b1},
    '{addr: 16'h3000, cnt: 10'd500, stall: 8'd0, midStart: 1'b0}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runJob(input logic [15:0] a, input logic [9:0] n,
                        input int stall, input bit mid);
    int reads = 0;
    int writes = 0;
    int firstRead = -1;
    int lastRead = -10;
    int doneAt = -1;
    int c = 0;
    logic [15:0] expA;
    logic [7:0]  expD;
    @(negedge clk);
    startAddr = a; byteCount = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (doneAt < 0 && c < 3000) begin
      devReady = !(c >= SETUP && c < SETUP + stall);
      devData  = 8'(reads * 37 + 5);
      if (mid && (c == SETUP + 1 || c == 3)) begin
        start = 1'b1; startAddr = 16'hABCD; byteCount = 10'd2;
      end else begin
        start = 1'b0;
      end
      #1;
      if (c == 0) check(busy == 1'b1, "R2", "busy in cycle 0", busy, 1);
      if (devRead) begin
        if (firstRead < 0) firstRead = c;
        lastRead = c;
        reads++;
      end
      if (memWe) begin
        expA = 16'(a + writes);
        expD = 8'(writes * 37 + 5);
        check(memAddr == expA, "R5", "write address", memAddr, expA);
        check(memData == expD, "R4", "write data", memData, expD);
        check(c == lastRead + 1, "R4", "write cycle after read", c, lastRead + 1);
        writes++;
      end
      if (done) doneAt = c;
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    devReady = 1'b1;
    #1;
    check(done == 1'b0, "R7", "done low after pulse", done, 0);
    check(busy == 1'b0, "R7", "busy low after done", busy, 0);
    if (n != 0)
      check(firstRead == SETUP + stall, "R3", "first read cycle", firstRead, SETUP + stall);
    if (mid)
      check(writes == int'(n), "R8", "writes despite mid start", writes, n);
    else if (n == 0)
      check(writes == 0, "R9", "writes for zero total", writes, 0);
    else
      check(writes == int'(n), "R4", "write count", writes, n);
    if (n == 0)
      check(doneAt == SETUP, "R9", "done cycle for zero total", doneAt, SETUP);
    else if (stall != 0)
      check(doneAt == SETUP + stall + 2 * int'(n), "R6", "done cycle with stall",
            doneAt, SETUP + stall + 2 * int'(n));
    else
      check(doneAt == SETUP + 2 * int'(n), "R7", "done cycle", doneAt, SETUP + 2 * int'(n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(devRead == 1'b0, "R1", "devRead in reset", devRead, 0);
    check(memWe == 1'b0, "R1", "memWe in reset", memWe, 0);
    @(negedge clk);
    rstN = 1'b1;
    devReady = 1'b1;
    @(negedge clk);
    #1;
    check(busy == 1'b0 && memWe == 1'b0, "R1", "idle after reset release", busy, 0);

    for (int i = 0; i < NV; i++)
      runJob(VECS[i].addr, VECS[i].cnt, int'(VECS[i].stall), VECS[i].midStart);

    // R9 zero total
    runJob(16'h0123, 10'd0, 0, 1'b0);
    // R6 longer stall on a single byte
    runJob(16'h7FFF, 10'd1, 9, 1'b0);
    // R8 mid start on a short job, then a clean job afterwards
    runJob(16'h0010, 10'd3, 0, 1'b1);
    runJob(16'h0020, 10'd2, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule